// File: doc/BRIEF.md
# Element-Width Packed Register File

This block is a file of 64-bit registers that is addressed as a flat byte store. Each access names a base register, an element index and an element width of 8, 16, 32 or 64 bits. Narrow elements are packed from the lowest byte of the base register upward and spill into the following registers in little-endian order. A write changes only the bytes of the addressed element. This lets a vector operation of any length leave the unused upper bytes of its last register as they were, instead of clearing them.

Three operations run in parallel. A combinational read port returns one element, zero-extended to 64 bits. A write port stores one element through per-byte enables. An element adder reads element i of two source vectors at a source width, sums them at the larger of the source and destination widths, and writes the low bytes of the sum into element i of a destination vector at the destination width. The two widths are chosen independently of each other.

The byte offset of an element is base*8 + index*bytes. Any access whose last byte would fall past the end of the file is reported and not carried out.

Top module: `elem_byte_rf`

## Requirements
- R1: Width codes 0, 1, 2 and 3 select 1, 2, 4 and 8 byte elements. A read of element i at base r returns the bytes starting at byte offset r*8 + i*bytes, with the lowest byte in bits 7:0, zero-extended to 64 bits.
- R2: An element whose byte offset runs past byte 7 of the base register continues into register r+1 and the registers after it. For example, 16-bit element 5 of base 0 occupies bytes 2 and 3 of register 1.
- R3: A write changes only the bytes of its element. Writing three 16-bit elements leaves bits 63:48 of the register as they were. Writing seven 8-bit elements leaves byte 7 as it was.
- R4: An access whose offset plus its byte count exceeds 256 is out of range. A read then returns zero and raises rdErr. A write then raises wrErr and changes nothing.
- R5: The adder writes to destination element i the low destination-width bytes of the sum of the two source elements, each read at the source width and zero-extended. The sum is formed at the larger of the two widths. All sixteen width pairs are allowed.
- R6: If either source element or the destination element of an add is out of range, addErr is raised and nothing is written.
- R7: When a write and an add hit the same byte in one cycle, the add's byte is stored. The bytes of the write that the add does not touch are still stored.
- R8: Reset clears every byte of the file to zero.
- R9: The add reads its sources as they were before the clock edge, even when the write port changes those bytes in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Write the element described by the wr* inputs |
| wrWidth | input | 2 | Write element width code |
| wrBase | input | 5 | Write base register |
| wrIdx | input | 8 | Write element index |
| wrData | input | 64 | Write data; the low bytes are stored |
| wrErr | output | 1 | Write requested but out of range |
| rdWidth | input | 2 | Read element width code |
| rdBase | input | 5 | Read base register |
| rdIdx | input | 8 | Read element index |
| rdData | output | 64 | Read element, zero-extended |
| rdErr | output | 1 | Read address out of range |
| addEn | input | 1 | Perform an element add |
| addSrcWidth | input | 2 | Width code of both source elements |
| addDstWidth | input | 2 | Width code of the destination element |
| addBaseA | input | 5 | Base register of the first source vector |
| addBaseB | input | 5 | Base register of the second source vector |
| addBaseD | input | 5 | Base register of the destination vector |
| addIdx | input | 8 | Element index shared by all three operands |
| addErr | output | 1 | Add requested but an operand is out of range |

## Verification
The write port and the adder's write-back can both land in the same cycle. They may target the same bytes, and the write may also alter the bytes the adder is reading. The bench provokes both cases. It issues a 64-bit write and a 16-bit add whose destination lies inside the written register. It also issues a write into a source element of a concurrent add. It then reads the whole register back and compares it with a byte model in which the write is applied first and the add overwrites only its own bytes, using source values taken from before the edge.

// File: rtl/elem_rf_pkg.sv
package elem_rf_pkg;
  parameter int RF_REGS  = 32;
  parameter int RF_IDX_W = 8;
  localparam int RF_BYTES = RF_REGS * 8;
  localparam int BYTE_AW  = $clog2(RF_BYTES);
  localparam int REG_AW   = $clog2(RF_REGS);
  localparam int OFF_W    = BYTE_AW + RF_IDX_W + 2;

  typedef logic [1:0]          widthCode_t;
  typedef logic [REG_AW-1:0]   regIdx_t;
  typedef logic [RF_IDX_W-1:0] elemIdx_t;
  typedef logic [OFF_W-1:0]    off_t;
  typedef logic [3:0]          len_t;

  // Strobes handed from control to datapath each cycle.
  typedef struct packed {
    logic wrGo;
    off_t wrOff;
    len_t wrLen;
    logic addGo;
    off_t addOffA;
    off_t addOffB;
    off_t addOffD;
    len_t addLenSrc;
    len_t addLenDst;
    len_t addLenMax;
    logic rdOk;
    off_t rdOff;
    len_t rdLen;
  } rfStrobes_t;

  function automatic len_t widthBytes(widthCode_t c);
    return len_t'(4'd1 << c);
  endfunction
endpackage

// File: rtl/elem_rf_ctrl.sv
module elem_rf_ctrl
  import elem_rf_pkg::*;
(
  input  logic       wrEn,
  input  widthCode_t wrWidth,
  input  regIdx_t    wrBase,
  input  elemIdx_t   wrIdx,
  input  widthCode_t rdWidth,
  input  regIdx_t    rdBase,
  input  elemIdx_t   rdIdx,
  input  logic       addEn,
  input  widthCode_t addSrcWidth,
  input  widthCode_t addDstWidth,
  input  regIdx_t    addBaseA,
  input  regIdx_t    addBaseB,
  input  regIdx_t    addBaseD,
  input  elemIdx_t   addIdx,
  output rfStrobes_t strb,
  output logic       wrErr,
  output logic       rdErr,
  output logic       addErr
);
  function automatic off_t placeOf(regIdx_t base, elemIdx_t idx, len_t len);
    return (off_t'(base) << 3) + off_t'(idx) * off_t'(len);
  endfunction

  function automatic logic fits(off_t off, len_t len);
    return (off + off_t'(len)) <= off_t'(RF_BYTES);
  endfunction

  len_t wrLen, rdLen, srcLen, dstLen;
  off_t wrOff, rdOff, offA, offB, offD;
  logic wrFits, rdFits, addFits;

  always_comb begin
    wrLen  = widthBytes(wrWidth);
    rdLen  = widthBytes(rdWidth);
    srcLen = widthBytes(addSrcWidth);
    dstLen = widthBytes(addDstWidth);
    wrOff  = placeOf(wrBase, wrIdx, wrLen);
    rdOff  = placeOf(rdBase, rdIdx, rdLen);
    offA   = placeOf(addBaseA, addIdx, srcLen);
    offB   = placeOf(addBaseB, addIdx, srcLen);
    offD   = placeOf(addBaseD, addIdx, dstLen);
    wrFits  = fits(wrOff, wrLen);
    rdFits  = fits(rdOff, rdLen);
    addFits = fits(offA, srcLen) && fits(offB, srcLen) && fits(offD, dstLen);

    strb.wrGo      = wrEn && wrFits;
    strb.wrOff     = wrOff;
    strb.wrLen     = wrLen;
    strb.addGo     = addEn && addFits;
    strb.addOffA   = offA;
    strb.addOffB   = offB;
    strb.addOffD   = offD;
    strb.addLenSrc = srcLen;
    strb.addLenDst = dstLen;
    strb.addLenMax = (srcLen > dstLen) ? srcLen : dstLen;
    strb.rdOk      = rdFits;
    strb.rdOff     = rdOff;
    strb.rdLen     = rdLen;

    wrErr  = wrEn && !wrFits;
    addErr = addEn && !addFits;
    rdErr  = !rdFits;
  end
endmodule

// File: rtl/elem_rf_data.sv
module elem_rf_data
  import elem_rf_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  rfStrobes_t  strb,
  input  logic [63:0] wrData,
  output logic [63:0] rdData
);
  logic [7:0] memView [RF_BYTES];

  function automatic logic [BYTE_AW-1:0] byteAt(off_t o, int k);
    off_t s;
    s = o + off_t'(k);
    return s[BYTE_AW-1:0];
  endfunction

  function automatic logic [63:0] lenMask(len_t len);
    return (len >= 4'd8) ? '1 : ((64'd1 << {len, 3'b000}) - 64'd1);
  endfunction

  logic [63:0] opA, opB, sumFull, sumMax;

  always_comb begin
    rdData = '0;
    opA    = '0;
    opB    = '0;
    for (int k = 0; k < 8; k++) begin
      if (strb.rdOk && (4'(k) < strb.rdLen))
        rdData[k*8 +: 8] = memView[byteAt(strb.rdOff, k)];
      if (4'(k) < strb.addLenSrc) begin
        opA[k*8 +: 8] = memView[byteAt(strb.addOffA, k)];
        opB[k*8 +: 8] = memView[byteAt(strb.addOffB, k)];
      end
    end
    sumFull = opA + opB;
    sumMax  = sumFull & lenMask(strb.addLenMax);
  end

  for (genvar b = 0; b < RF_BYTES; b++) begin : g_byte
    localparam off_t B_OFF = off_t'(b);
    logic [7:0] q;
    off_t wrDiff, addDiff;
    logic wrHit, addHit;
    logic [2:0] wrRel, addRel;

    always_comb begin
      wrDiff  = B_OFF - strb.wrOff;
      addDiff = B_OFF - strb.addOffD;
      wrHit   = strb.wrGo && (B_OFF >= strb.wrOff) && (wrDiff < off_t'(strb.wrLen));
      addHit  = strb.addGo && (B_OFF >= strb.addOffD) && (addDiff < off_t'(strb.addLenDst));
      wrRel   = wrDiff[2:0];
      addRel  = addDiff[2:0];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)       q <= '0;
      else if (addHit) q <= sumMax[addRel*8 +: 8];
      else if (wrHit)  q <= wrData[wrRel*8 +: 8];
    end

    assign memView[b] = q;

    // R7
    overlap_add_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
      (addHit && wrHit) |=> (q == $past(sumMax[addRel*8 +: 8])));
  end

  // R1
  rd_zero_ext_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdLen < 4'd8) |-> ((rdData >> {strb.rdLen, 3'b000}) == 64'd0));
endmodule

// File: rtl/elem_byte_rf.sv
module elem_byte_rf
  import elem_rf_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [1:0]  wrWidth,
  input  logic [4:0]  wrBase,
  input  logic [7:0]  wrIdx,
  input  logic [63:0] wrData,
  output logic        wrErr,
  input  logic [1:0]  rdWidth,
  input  logic [4:0]  rdBase,
  input  logic [7:0]  rdIdx,
  output logic [63:0] rdData,
  output logic        rdErr,
  input  logic        addEn,
  input  logic [1:0]  addSrcWidth,
  input  logic [1:0]  addDstWidth,
  input  logic [4:0]  addBaseA,
  input  logic [4:0]  addBaseB,
  input  logic [4:0]  addBaseD,
  input  logic [7:0]  addIdx,
  output logic        addErr
);
  rfStrobes_t strb;

  elem_rf_ctrl u_ctrl (
    .wrEn(wrEn), .wrWidth(wrWidth), .wrBase(wrBase), .wrIdx(wrIdx),
    .rdWidth(rdWidth), .rdBase(rdBase), .rdIdx(rdIdx),
    .addEn(addEn), .addSrcWidth(addSrcWidth), .addDstWidth(addDstWidth),
    .addBaseA(addBaseA), .addBaseB(addBaseB), .addBaseD(addBaseD), .addIdx(addIdx),
    .strb(strb), .wrErr(wrErr), .rdErr(rdErr), .addErr(addErr)
  );

  elem_rf_data u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData), .rdData(rdData)
  );

  logic [63:0] wrMask;
  assign wrMask = (wrWidth == 2'd3) ? '1 : ((64'd1 << (6'd8 << wrWidth)) - 64'd1);

  // R4
  rd_err_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdErr |-> (rdData == 64'd0));

  // R3
  wr_persist_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !wrErr && !addEn) |=>
      ((rdBase != $past(wrBase)) || (rdIdx != $past(wrIdx)) ||
       (rdWidth != $past(wrWidth)) || (rdData == $past(wrData & wrMask))));
endmodule

// File: tb/elem_byte_rf_test.sv
module elem_byte_rf_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrWidth = '0;
  logic [4:0]  wrBase = '0;
  logic [7:0]  wrIdx = '0;
  logic [63:0] wrData = '0;
  logic        wrErr;
  logic [1:0]  rdWidth = '0;
  logic [4:0]  rdBase = '0;
  logic [7:0]  rdIdx = '0;
  logic [63:0] rdData;
  logic        rdErr;
  logic        addEn = 1'b0;
  logic [1:0]  addSrcWidth = '0;
  logic [1:0]  addDstWidth = '0;
  logic [4:0]  addBaseA = '0;
  logic [4:0]  addBaseB = '0;
  logic [4:0]  addBaseD = '0;
  logic [7:0]  addIdx = '0;
  logic        addErr;

  int errors = 0;
  int checks = 0;
  logic [7:0] model [256];

  elem_byte_rf uut (
    .clk(clk), .rstN(rstN),
    .wrEn(wrEn), .wrWidth(wrWidth), .wrBase(wrBase), .wrIdx(wrIdx), .wrData(wrData), .wrErr(wrErr),
    .rdWidth(rdWidth), .rdBase(rdBase), .rdIdx(rdIdx), .rdData(rdData), .rdErr(rdErr),
    .addEn(addEn), .addSrcWidth(addSrcWidth), .addDstWidth(addDstWidth),
    .addBaseA(addBaseA), .addBaseB(addBaseB), .addBaseD(addBaseD), .addIdx(addIdx), .addErr(addErr)
  );

  always #2 clk = ~clk;

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  function automatic int lenOf(int w);
    return 1 << w;
  endfunction

  function automatic bit oob(int w, int base, int idx);
    return (base * 8 + idx * lenOf(w) + lenOf(w)) > 256;
  endfunction

  function automatic logic [63:0] mRead(int w, int base, int idx);
    logic [63:0] v = '0;
    if (oob(w, base, idx)) return '0;
    for (int k = 0; k < lenOf(w); k++) v[k*8 +: 8] = model[base*8 + idx*lenOf(w) + k];
    return v;
  endfunction

  task automatic mWrite(int w, int base, int idx, logic [63:0] d);
    if (!oob(w, base, idx))
      for (int k = 0; k < lenOf(w); k++) model[base*8 + idx*lenOf(w) + k] = d[k*8 +: 8];
  endtask

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic readChk(int w, int base, int idx, string req);
    rdWidth = 2'(w); rdBase = 5'(base); rdIdx = 8'(idx);
    #1;
    chk(rdData === mRead(w, base, idx), req, rdData, mRead(w, base, idx));
    chk(rdErr === oob(w, base, idx), req, 64'(rdErr), 64'(oob(w, base, idx)));
  endtask

  task automatic readVal(int w, int base, int idx, logic [63:0] exp, string req);
    rdWidth = 2'(w); rdBase = 5'(base); rdIdx = 8'(idx);
    #1;
    chk(rdData === exp, req, rdData, exp);
  endtask

  task automatic sweepAll(string req);
    for (int r = 0; r < 32; r++) readChk(3, r, 0, req);
  endtask

  task automatic doWrite(int w, int base, int idx, logic [63:0] d, string req);
    wrEn = 1'b1; wrWidth = 2'(w); wrBase = 5'(base); wrIdx = 8'(idx); wrData = d;
    #1;
    chk(wrErr === oob(w, base, idx), req, 64'(wrErr), 64'(oob(w, base, idx)));
    mWrite(w, base, idx, d);
    tick();
    wrEn = 1'b0;
  endtask

  task automatic setAdd(int sw, int dw, int a, int b, int d, int idx);
    addEn = 1'b1; addSrcWidth = 2'(sw); addDstWidth = 2'(dw);
    addBaseA = 5'(a); addBaseB = 5'(b); addBaseD = 5'(d); addIdx = 8'(idx);
  endtask

  task automatic doAdd(int sw, int dw, int a, int b, int d, int idx, string req);
    bit err;
    logic [63:0] s;
    err = oob(sw, a, idx) || oob(sw, b, idx) || oob(dw, d, idx);
    s = mRead(sw, a, idx) + mRead(sw, b, idx);
    setAdd(sw, dw, a, b, d, idx);
    #1;
    chk(addErr === err, req, 64'(addErr), 64'(err));
    if (!err) mWrite(dw, d, idx, s);
    tick();
    addEn = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) model[i] = 8'h00;
    #1;
    repeat (3) tick();
    rstN = 1'b1;
    tick();

    // R8: every register reads zero after reset
    sweepAll("R8");

    // R1: each width, several indices, then whole-file compare
    for (int w = 0; w < 4; w++)
      for (int i = 0; i < 4; i++) begin
        doWrite(w, 8 + w * 4, i, 64'hA1B2_C3D4_E5F6_0718 ^ (64'(i) * 64'h0101_0101_0101_0101), "R1");
        readChk(w, 8 + w * 4, i, "R1");
      end
    sweepAll("R1");

    // R2: packing spills into following registers
    doWrite(1, 0, 5, 64'h0000_0000_0000_BEEF, "R2");
    readVal(3, 1, 0, 64'h0000_0000_BEEF_0000, "R2");
    doWrite(2, 2, 3, 64'h0000_0000_1234_5678, "R2");
    readVal(3, 3, 0, 64'h1234_5678_0000_0000, "R2");

    // R3: partial vectors leave the upper bytes alone
    doWrite(3, 5, 0, 64'hFFFF_FFFF_FFFF_FFFF, "R3");
    for (int i = 0; i < 3; i++) doWrite(1, 5, i, 64'h0000_0000_0000_1111 * 64'(i + 1), "R3");
    readVal(3, 5, 0, 64'hFFFF_3333_2222_1111, "R3");
    doWrite(3, 7, 0, 64'hEEEE_EEEE_EEEE_EEEE, "R3");
    for (int i = 0; i < 7; i++) doWrite(0, 7, i, 64'(i + 1), "R3");
    readVal(3, 7, 0, 64'hEE07_0605_0403_0201, "R3");
    sweepAll("R3");

    // R4: out-of-range reads and writes
    readChk(3, 31, 1, "R4");
    readChk(0, 31, 7, "R4");
    readChk(0, 31, 8, "R4");
    readChk(2, 30, 4, "R4");
    doWrite(3, 31, 1, 64'hDEAD_DEAD_DEAD_DEAD, "R4");
    doWrite(1, 28, 16, 64'hDEAD_DEAD_DEAD_DEAD, "R4");
    sweepAll("R4");

    // R5: all sixteen width pairs
    doWrite(3, 4, 0, 64'hFEDC_BA98_7654_3210, "R5");
    doWrite(3, 5, 0, 64'hF0E1_D2C3_B4A5_9687, "R5");
    doWrite(3, 6, 0, 64'h8899_AABB_CCDD_EEFF, "R5");
    doWrite(3, 7, 0, 64'h7F80_7F80_FFFF_0101, "R5");
    for (int sw = 0; sw < 4; sw++)
      for (int dw = 0; dw < 4; dw++) begin
        doWrite(3, 12, 0, 64'h5555_5555_5555_5555, "R5");
        doWrite(3, 13, 0, 64'h5555_5555_5555_5555, "R5");
        doAdd(sw, dw, 4, 6, 12, 1, "R5");
        readChk(dw, 12, 1, "R5");
        readChk(3, 12, 0, "R5");
        readChk(3, 13, 0, "R5");
      end

    // R6: any operand out of range blocks the add
    doAdd(3, 3, 4, 6, 31, 1, "R6");
    doAdd(3, 0, 31, 6, 12, 1, "R6");
    doAdd(0, 0, 4, 31, 12, 8, "R6");
    sweepAll("R6");

    // R7: same-cycle write and add to the same register
    wrEn = 1'b1; wrWidth = 2'd3; wrBase = 5'd10; wrIdx = 8'd0; wrData = 64'h0123_4567_89AB_CDEF;
    begin
      logic [63:0] s;
      s = mRead(1, 4, 1) + mRead(1, 6, 1);
      mWrite(3, 10, 0, 64'h0123_4567_89AB_CDEF);
      mWrite(1, 10, 1, s);
    end
    setAdd(1, 1, 4, 6, 10, 1);
    tick();
    wrEn = 1'b0; addEn = 1'b0;
    readChk(3, 10, 0, "R7");

    // R9: add sources sampled before a same-cycle write to them
    wrEn = 1'b1; wrWidth = 2'd2; wrBase = 5'd4; wrIdx = 8'd1; wrData = 64'h0000_0000_0000_0001;
    begin
      logic [63:0] s;
      s = mRead(2, 4, 1) + mRead(2, 6, 1);
      mWrite(2, 4, 1, 64'h1);
      mWrite(3, 20, 1, s);
    end
    setAdd(2, 3, 4, 6, 20, 1);
    tick();
    wrEn = 1'b0; addEn = 1'b0;
    readChk(3, 21, 0, "R9");
    readChk(3, 4, 0, "R9");
    sweepAll("R9");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule